// File: doc/BRIEF.md
# Converter Clock-Fault Recovery Controller

This block is the supervisory state machine of a power-management device. It responds to a switching-clock fault on the boost converter. It moves the device between five states: RESET, DIAGNOSTIC, ACTIVE, SAFE and OFF. On a clock fault it shuts the boost off and parks the device in SAFE. If the configuration makes boost undervoltage a reset condition, the device returns to RESET once the output has discharged. From there the boost is restarted only when two things hold: the output is below its restart level and the clock monitor reports a healthy clock.

After the boost ramps up, a self-test runs while the reset output is held extended. A pass leads through DIAGNOSTIC into ACTIVE. A failure counts one error and goes back to SAFE, so the recovery loop repeats. The loop ends in OFF when the error count reaches its limit, or when the boost fails to ramp within a cycle budget. OFF holds until a synchronous power-on reset.

If undervoltage is not a reset condition, the device stays in SAFE while the output discharges, and only the host can switch the boost back on. While in SAFE, the host may also turn clock monitoring off for good. Analog sensing, the content of the self-test and the register interface are outside this block; all of its inputs are already-qualified single-bit flags.

Top module: `clkfault_recovery_ctrl`

## Requirements
- R1: A clock fault is `clk_err_i` high while `osc_ok_i` is high and monitoring is enabled. A fault in RESET, DIAGNOSTIC or ACTIVE moves the state to SAFE with boost off on the next edge. In SAFE, a fault turns boost off. With `osc_ok_i` low, `clk_err_i` has no effect.
- R2: `state_o` is encoded as RESET=0, DIAGNOSTIC=1, ACTIVE=2, SAFE=3, OFF=4. After `rst_n` low, or after one edge with `por_i` high, the outputs are: state RESET, `boost_en_o`=0, `rst_ext_o`=0, `bist_start_o`=0, `err_cnt_o`=0, and monitoring is enabled.
- R3: In RESET with boost off, boost is switched on only in a cycle where `below_restart_i` is high and `clk_err_i` is low. Otherwise boost stays off.
- R4: With boost on in RESET, the self-test begins when `ramp_done_i` is high and there is no reset condition. A reset condition is `uv_is_rst_i` and `uv_i` both high. During the self-test, `rst_ext_o` is high, and `bist_start_o` is high only in its first cycle. `bist_done_i` with `bist_pass_i` high leads to DIAGNOSTIC for one cycle, then to ACTIVE.
- R5: `bist_done_i` with `bist_pass_i` low turns boost off, moves the state to SAFE and adds one to `err_cnt_o`.
- R6: A failed self-test that brings `err_cnt_o` to ERR_MAX moves the state to OFF instead of SAFE. OFF keeps boost off and ignores every input except `por_i`.
- R7: Once boost is switched on in RESET, it has TMO_CYC cycles, counting the first, to see a ramp-done with no reset condition. Ramp-done in the last of those cycles is accepted. If none arrives, the next state is OFF.
- R8: In SAFE with `uv_is_rst_i`=1, `uv_i` high moves the state to RESET with boost off, and `host_boost_en_i` is ignored. With `uv_is_rst_i`=0, the device stays in SAFE whatever `uv_i` does, and `host_boost_en_i` switches boost on.
- R9: `host_mon_dis_i` in SAFE disables clock monitoring until reset, after which R1 faults are ignored. Outside SAFE, `host_mon_dis_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_i | input | 1 | Synchronous power-on reset; the only exit from OFF |
| clk_err_i | input | 1 | Boost switching-clock error flag from the monitor |
| osc_ok_i | input | 1 | Internal oscillator good |
| uv_i | input | 1 | Boost output below undervoltage threshold |
| below_restart_i | input | 1 | Boost output below restart level |
| ramp_done_i | input | 1 | Boost ramp-up complete |
| bist_pass_i | input | 1 | Self-test result, valid with bist_done_i |
| bist_done_i | input | 1 | Self-test finished |
| uv_is_rst_i | input | 1 | Configuration: boost undervoltage is a reset condition |
| host_boost_en_i | input | 1 | Host request to switch boost on |
| host_mon_dis_i | input | 1 | Host request to disable clock monitoring |
| state_o | output | 3 | Current device state (R2 encoding) |
| boost_en_o | output | 1 | Boost converter enable |
| rst_ext_o | output | 1 | Reset extension active (self-test running) |
| bist_start_o | output | 1 | One-cycle self-test start pulse |
| err_cnt_o | output | $clog2(ERR_MAX+1) | Saturating self-test failure count |

## Verification
The bench builds the block with TMO_CYC=8 and ERR_MAX=3. With these values, the full retry loop runs to OFF after three failed self-tests within a short vector table. The ramp time-out can be walked cycle by cycle, which checks both sides of the limit: a ramp-done in the eighth cycle is accepted, and no ramp-done leads to OFF on the following edge.

// File: rtl/clkrec_pkg.sv
package clkrec_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_DIAG   = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_SAFE   = 3'd3,
    ST_OFF    = 3'd4
  } dev_state_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_RAMP = 2'd1,
    PH_BIST = 2'd2
  } rst_phase_e;

endpackage

// File: rtl/clkrec_ramp_timer.sv
module clkrec_ramp_timer #(
  parameter int TMO_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired_o = run_i && (cnt_q == LAST);

  always_comb begin
    if (clr_i || !run_i || expired_o) cnt_d = '0;
    else                              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7
  tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < TMO_CYC);

  // R7
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0);

endmodule

// File: rtl/clkrec_err_cnt.sv
module clkrec_err_cnt #(
  parameter int ERR_MAX = 4,
  localparam int EW = $clog2(ERR_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [EW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [EW-1:0] TOP = EW'(ERR_MAX);

  logic [EW-1:0] cnt_q, cnt_d;

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == TOP - EW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                     cnt_d = '0;
    else if (inc_i && cnt_q != TOP) cnt_d = cnt_q + EW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + EW'(1)));

  // R6
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

endmodule

// File: rtl/clkrec_fsm.sv
module clkrec_fsm
  import clkrec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       clk_err_i,
  input  logic       osc_ok_i,
  input  logic       uv_i,
  input  logic       below_restart_i,
  input  logic       ramp_done_i,
  input  logic       bist_pass_i,
  input  logic       bist_done_i,
  input  logic       uv_is_rst_i,
  input  logic       host_boost_en_i,
  input  logic       host_mon_dis_i,
  input  logic       tmo_i,
  input  logic       err_last_i,
  output logic [2:0] state_o,
  output logic       boost_en_o,
  output logic       rst_ext_o,
  output logic       bist_start_o,
  output logic       err_inc_o,
  output logic       timer_run_o
);
  dev_state_e state_q, state_d;
  rst_phase_e phase_q, phase_d;
  logic boost_q, boost_d;
  logic start_q, start_d;
  logic mon_dis_q, mon_dis_d;
  logic fault, rst_cond;

  assign fault    = clk_err_i && osc_ok_i && !mon_dis_q;
  assign rst_cond = uv_is_rst_i && uv_i;

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    boost_d   = boost_q;
    start_d   = 1'b0;
    mon_dis_d = mon_dis_q;
    err_inc_o = 1'b0;
    if (por_i) begin
      state_d   = ST_RESET;
      phase_d   = PH_WAIT;
      boost_d   = 1'b0;
      mon_dis_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_RESET: begin
          if (fault) begin
            state_d = ST_SAFE;
            phase_d = PH_WAIT;
            boost_d = 1'b0;
          end else begin
            unique case (phase_q)
              PH_WAIT: if (below_restart_i && !clk_err_i) begin
                boost_d = 1'b1;
                phase_d = PH_RAMP;
              end
              PH_RAMP: if (ramp_done_i && !rst_cond) begin
                phase_d = PH_BIST;
                start_d = 1'b1;
              end else if (tmo_i) begin
                state_d = ST_OFF;
                phase_d = PH_WAIT;
                boost_d = 1'b0;
              end
              PH_BIST: if (bist_done_i) begin
                phase_d = PH_WAIT;
                if (bist_pass_i) begin
                  state_d = ST_DIAG;
                end else begin
                  err_inc_o = 1'b1;
                  boost_d   = 1'b0;
                  state_d   = err_last_i ? ST_OFF : ST_SAFE;
                end
              end
              default: phase_d = PH_WAIT;
            endcase
          end
        end
        ST_DIAG: begin
          if (fault) begin
            state_d = ST_SAFE;
            boost_d = 1'b0;
          end else begin
            state_d = ST_ACTIVE;
          end
        end
        ST_ACTIVE: if (fault) begin
          state_d = ST_SAFE;
          boost_d = 1'b0;
        end
        ST_SAFE: begin
          if (host_mon_dis_i) mon_dis_d = 1'b1;
          if (fault) begin
            boost_d = 1'b0;
          end else if (rst_cond) begin
            state_d = ST_RESET;
            phase_d = PH_WAIT;
            boost_d = 1'b0;
          end else if (!uv_is_rst_i && host_boost_en_i) begin
            boost_d = 1'b1;
          end
        end
        default: begin
          state_d = ST_OFF;
          boost_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RESET;
      phase_q   <= PH_WAIT;
      boost_q   <= 1'b0;
      start_q   <= 1'b0;
      mon_dis_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      boost_q   <= boost_d;
      start_q   <= start_d;
      mon_dis_q <= mon_dis_d;
    end
  end

  assign state_o      = state_q;
  assign boost_en_o   = boost_q;
  assign bist_start_o = start_q;
  assign rst_ext_o    = (state_q == ST_RESET) && (phase_q == PH_BIST);
  assign timer_run_o  = (state_q == ST_RESET) && (phase_q == PH_RAMP);

  // R1
  osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && !osc_ok_i && !por_i) |=> state_q == ST_ACTIVE);

  // R3
  restart_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET && phase_q == PH_WAIT && !(below_restart_i && !clk_err_i))
      |=> !boost_q);

  // R4
  start_in_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> rst_ext_o);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R6
  off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !por_i) |=> (state_q == ST_OFF && !boost_q));

  // R9
  mon_dis_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_dis_q && !por_i) |=> mon_dis_q);

endmodule

// File: rtl/clkfault_recovery_ctrl.sv
module clkfault_recovery_ctrl #(
  parameter int TMO_CYC = 1024,
  parameter int ERR_MAX = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         por_i,
  input  logic                         clk_err_i,
  input  logic                         osc_ok_i,
  input  logic                         uv_i,
  input  logic                         below_restart_i,
  input  logic                         ramp_done_i,
  input  logic                         bist_pass_i,
  input  logic                         bist_done_i,
  input  logic                         uv_is_rst_i,
  input  logic                         host_boost_en_i,
  input  logic                         host_mon_dis_i,
  output logic [2:0]                   state_o,
  output logic                         boost_en_o,
  output logic                         rst_ext_o,
  output logic                         bist_start_o,
  output logic [$clog2(ERR_MAX+1)-1:0] err_cnt_o
);
  logic tmo, err_last, err_inc, timer_run;

  clkrec_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .por_i           (por_i),
    .clk_err_i       (clk_err_i),
    .osc_ok_i        (osc_ok_i),
    .uv_i            (uv_i),
    .below_restart_i (below_restart_i),
    .ramp_done_i     (ramp_done_i),
    .bist_pass_i     (bist_pass_i),
    .bist_done_i     (bist_done_i),
    .uv_is_rst_i     (uv_is_rst_i),
    .host_boost_en_i (host_boost_en_i),
    .host_mon_dis_i  (host_mon_dis_i),
    .tmo_i           (tmo),
    .err_last_i      (err_last),
    .state_o         (state_o),
    .boost_en_o      (boost_en_o),
    .rst_ext_o       (rst_ext_o),
    .bist_start_o    (bist_start_o),
    .err_inc_o       (err_inc),
    .timer_run_o     (timer_run)
  );

  clkrec_ramp_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (por_i),
    .run_i     (timer_run),
    .expired_o (tmo)
  );

  clkrec_err_cnt #(.ERR_MAX(ERR_MAX)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (por_i),
    .inc_i  (err_inc),
    .cnt_o  (err_cnt_o),
    .last_o (err_last)
  );

endmodule

// File: tb/clkfault_recovery_ctrl_tb.sv
`timescale 1ns/1ps
module clkfault_recovery_ctrl_tb;
  // stimulus bits: {clk_err, osc_ok, uv, below, ramp, pass, done, cfg, host_be, host_md}
  localparam logic [9:0] B_ERR = 10'h200, B_OSC = 10'h100, B_UV = 10'h080,
                         B_BELOW = 10'h040, B_RAMP = 10'h020, B_PASS = 10'h010,
                         B_DONE = 10'h008, B_CFG = 10'h004, B_HBE = 10'h002,
                         B_HMD = 10'h001;
  localparam logic [9:0] I  = B_OSC | B_CFG;
  localparam logic [9:0] NO = B_CFG;
  localparam logic [9:0] C0 = B_OSC;
  // expected: {state[2:0], boost, rst_ext, bist_start, err[1:0]}
  localparam int NV = 25;
  localparam logic [17:0] VEC [NV] = '{
    {I | B_BELOW,          3'd0, 1'b1, 1'b0, 1'b0, 2'd0}, // R3
    {I | B_RAMP,           3'd0, 1'b1, 1'b1, 1'b1, 2'd0}, // R4
    {I,                    3'd0, 1'b1, 1'b1, 1'b0, 2'd0}, // R4
    {I | B_DONE | B_PASS,  3'd1, 1'b1, 1'b0, 1'b0, 2'd0}, // R4
    {I,                    3'd2, 1'b1, 1'b0, 1'b0, 2'd0}, // R4
    {I,                    3'd2, 1'b1, 1'b0, 1'b0, 2'd0}, // R4
    {NO | B_ERR,           3'd2, 1'b1, 1'b0, 1'b0, 2'd0}, // R1
    {I | B_ERR,            3'd3, 1'b0, 1'b0, 1'b0, 2'd0}, // R1
    {I,                    3'd3, 1'b0, 1'b0, 1'b0, 2'd0}, // R8
    {I | B_UV,             3'd0, 1'b0, 1'b0, 1'b0, 2'd0}, // R8
    {I | B_UV,             3'd0, 1'b0, 1'b0, 1'b0, 2'd0}, // R3
    {NO | B_ERR | B_BELOW, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0}, // R3
    {I | B_BELOW,          3'd0, 1'b1, 1'b0, 1'b0, 2'd0}, // R3
    {I | B_RAMP | B_UV,    3'd0, 1'b1, 1'b0, 1'b0, 2'd0}, // R4
    {I | B_RAMP,           3'd0, 1'b1, 1'b1, 1'b1, 2'd0}, // R4
    {I | B_DONE,           3'd3, 1'b0, 1'b0, 1'b0, 2'd1}, // R5
    {I | B_UV,             3'd0, 1'b0, 1'b0, 1'b0, 2'd1}, // R5
    {I | B_BELOW,          3'd0, 1'b1, 1'b0, 1'b0, 2'd1}, // R5
    {I | B_RAMP,           3'd0, 1'b1, 1'b1, 1'b1, 2'd1}, // R5
    {I | B_DONE,           3'd3, 1'b0, 1'b0, 1'b0, 2'd2}, // R5
    {I | B_UV,             3'd0, 1'b0, 1'b0, 1'b0, 2'd2}, // R5
    {I | B_BELOW,          3'd0, 1'b1, 1'b0, 1'b0, 2'd2}, // R6
    {I | B_RAMP,           3'd0, 1'b1, 1'b1, 1'b1, 2'd2}, // R6
    {I | B_DONE,           3'd4, 1'b0, 1'b0, 1'b0, 2'd3}, // R6
    {I | B_BELOW | B_UV | B_HBE, 3'd4, 1'b0, 1'b0, 1'b0, 2'd3} // R6
  };
  localparam string VREQ [NV] = '{"R3","R4","R4","R4","R4","R4","R1","R1","R8","R8",
    "R3","R3","R3","R4","R4","R5","R5","R5","R5","R5","R5","R6","R6","R6","R6"};

  logic clk = 1'b0;
  logic rst_n, por;
  logic [9:0] stim;
  logic [2:0] state;
  logic boost, ext, start;
  logic [1:0] err;
  int tests = 0, fails = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  clkfault_recovery_ctrl #(.TMO_CYC(8), .ERR_MAX(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_i(por),
    .clk_err_i(stim[9]), .osc_ok_i(stim[8]), .uv_i(stim[7]),
    .below_restart_i(stim[6]), .ramp_done_i(stim[5]), .bist_pass_i(stim[4]),
    .bist_done_i(stim[3]), .uv_is_rst_i(stim[2]), .host_boost_en_i(stim[1]),
    .host_mon_dis_i(stim[0]),
    .state_o(state), .boost_en_o(boost), .rst_ext_o(ext),
    .bist_start_o(start), .err_cnt_o(err)
  );

  task automatic check(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {state, boost, ext, start, err};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [9:0] s, input logic [7:0] exp);
    stim = s;
    @(posedge clk);
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic do_por(input string req);
    por = 1'b1;
    step(req, I, {3'd0, 1'b0, 1'b0, 1'b0, 2'd0});
    por = 1'b0;
  endtask

  task automatic idle_n(input int n);
    for (int k = 0; k < n; k++) begin
      stim = I;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    por   = 1'b0;
    stim  = I;
    #10;
    @(negedge clk);
    rst_n = 1'b1;
    check("R2 reset", {3'd0, 1'b0, 1'b0, 1'b0, 2'd0});

    for (int v = 0; v < NV; v++) step(VREQ[v], VEC[v][17:8], VEC[v][7:0]);

    // R6 / R2: only power-on reset leaves OFF and clears the count
    do_por("R6 por exit");

    // R7: no ramp-done within 8 cycles -> OFF
    step("R7 enable", I | B_BELOW, {3'd0, 1'b1, 1'b0, 1'b0, 2'd0});
    idle_n(7);
    check("R7 before limit", {3'd0, 1'b1, 1'b0, 1'b0, 2'd0});
    step("R7 timeout", I, {3'd4, 1'b0, 1'b0, 1'b0, 2'd0});

    // R7: ramp-done in the last allowed cycle is accepted
    do_por("R2 por");
    step("R7 enable", I | B_BELOW, {3'd0, 1'b1, 1'b0, 1'b0, 2'd0});
    idle_n(7);
    step("R7 last cycle", I | B_RAMP, {3'd0, 1'b1, 1'b1, 1'b1, 2'd0});

    // R9 / R8: host controls
    do_por("R2 por");
    step("R3", I | B_BELOW, {3'd0, 1'b1, 1'b0, 1'b0, 2'd0});
    step("R4", I | B_RAMP, {3'd0, 1'b1, 1'b1, 1'b1, 2'd0});
    step("R4", I | B_DONE | B_PASS, {3'd1, 1'b1, 1'b0, 1'b0, 2'd0});
    step("R4", I, {3'd2, 1'b1, 1'b0, 1'b0, 2'd0});
    step("R9 md outside safe", I | B_HMD, {3'd2, 1'b1, 1'b0, 1'b0, 2'd0});
    step("R9 still monitored", I | B_ERR, {3'd3, 1'b0, 1'b0, 1'b0, 2'd0});
    step("R8 hbe ignored cfg1", I | B_HBE, {3'd3, 1'b0, 1'b0, 1'b0, 2'd0});
    step("R8 stay safe cfg0", C0 | B_UV, {3'd3, 1'b0, 1'b0, 1'b0, 2'd0});
    step("R8 host boost", C0 | B_HBE, {3'd3, 1'b1, 1'b0, 1'b0, 2'd0});
    step("R1 fault in safe", C0 | B_ERR, {3'd3, 1'b0, 1'b0, 1'b0, 2'd0});
    step("R9 disable", C0 | B_HMD, {3'd3, 1'b0, 1'b0, 1'b0, 2'd0});
    step("R8 host boost", C0 | B_HBE, {3'd3, 1'b1, 1'b0, 1'b0, 2'd0});
    step("R9 err ignored", C0 | B_ERR, {3'd3, 1'b1, 1'b0, 1'b0, 2'd0});

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule